// File: doc/BRIEF.md
# Crystal Oscillator Startup Delay Controller

This block turns an external crystal oscillator on and off and reports when the oscillator can be trusted. Software writes a configuration word that holds an enable bit and an 8-bit startup count. An enable write drives the mode-select output that puts the oscillator pins into oscillator mode, and it starts a startup delay. The delay is measured in pulses of a slow-clock tick input, divided by eight by an internal prescaler. When the countdown ends, a stable flag is set.

Clearing the enable bit stops the oscillator and drops the stable flag at once. An enable write made while the oscillator is already running starts the delay again. A one-bit interrupt mask gates the stable flag onto a level-sensitive interrupt request. All logic runs on one clock. The slow clock reaches the block as a one-cycle tick strobe.

Top module: `osc_startup_delay`

## Requirements
- R1: After reset, oscModeSel, stable and irq are 0, and the interrupt mask is 0.
- R2: A cycle with cfgWr=1 and cfgEnable=1 sets oscModeSel to 1 and clears stable at the next edge. It loads cfgCount as the startup count and starts the countdown. This also applies when the oscillator is already enabled or already stable.
- R3: A cycle with cfgWr=1 and cfgEnable=0 clears oscModeSel and stable at the next edge.
- R4: With startup count N in 1..255, stable becomes 1 at the edge that samples the (8*N)-th slowTick pulse counted after the enable write. It stays 0 before that edge.
- R5: A startup count of 0 behaves like a count of 1, so stable rises on the 8th counted slowTick pulse.
- R6: slowTick pulses have no effect while the oscillator is disabled, and they have no effect in the same cycle as a cfgWr.
- R7: Each enable write resets the divide-by-8 prescaler. Ticks counted before a re-enable do not shorten the new delay.
- R8: Once set, stable stays 1 until the next cfgWr, whatever slowTick does.
- R9: irq equals stable AND the mask bit. A cycle with maskWr=1 loads maskVal into the mask at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Oscillator enable bit of the configuration write |
| cfgCount | input | 8 | Startup count of the configuration write |
| maskWr | input | 1 | Interrupt mask write strobe |
| maskVal | input | 1 | Interrupt mask value |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| oscModeSel | output | 1 | Switches the oscillator pins into oscillator mode |
| stable | output | 1 | Oscillator startup delay has elapsed |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that cfgWr, maskWr and slowTick are synchronous single-cycle strobes, sampled only at rising clock edges. They also assume that slowTick counts only when it is high in a cycle without a configuration write. On that basis, the load, hold and clear properties compare the counter and the flag with the write strobes of the previous cycle. The stimulus changes every input on the falling edge. It holds slowTick low during every write cycle, except one deliberate case that checks a coincident tick is dropped. It drives ticks in unbroken runs, so the expected edge for each count is simply eight times that count.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic load;   // enable write: load count, clear prescaler
    logic halt;   // disable write: clear counter and prescaler
    logic step;   // counted slow tick
  } dpStrobe_t;
endpackage

// File: rtl/osc_start_dp.sv
module osc_start_dp
  import osc_startup_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic             expire
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] downCnt;
  logic             wrapTick;
  logic             lastStep;

  assign wrapTick = strobe.step && (preCnt == PRE_LAST);
  assign lastStep = (downCnt <= CNT_ONE);
  assign expire   = wrapTick && lastStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      downCnt <= '0;
    end else if (strobe.load) begin
      preCnt  <= '0;
      downCnt <= loadValue;
    end else if (strobe.halt) begin
      preCnt  <= '0;
      downCnt <= '0;
    end else if (strobe.step) begin
      preCnt <= preCnt + 1'b1;
      if (wrapTick) begin
        downCnt <= lastStep ? '0 : downCnt - CNT_ONE;
      end
    end
  end

  // R7: an enable write restarts prescaler and loads the count
  a_r7_load_restart : assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (preCnt == '0 && downCnt == $past(loadValue)));

  // R6: with no counted tick and no write, the countdown state is frozen
  a_r6_hold_idle : assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.halt || strobe.step) |=> ($stable(preCnt) && $stable(downCnt)));

  // R3: a disable write empties the counter
  a_r3_halt_clears : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.halt && !strobe.load) |=> (downCnt == '0 && preCnt == '0));
endmodule

// File: rtl/osc_start_ctrl.sv
module osc_start_ctrl
  import osc_startup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWr,
  input  logic      cfgEnable,
  input  logic      maskWr,
  input  logic      maskVal,
  input  logic      slowTick,
  input  logic      expire,
  output dpStrobe_t strobe,
  output logic      oscModeSel,
  output logic      stable,
  output logic      irq
);
  logic enReg;
  logic stableReg;
  logic maskReg;

  always_comb begin
    strobe.load = cfgWr && cfgEnable;
    strobe.halt = cfgWr && !cfgEnable;
    strobe.step = slowTick && enReg && !stableReg && !cfgWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      stableReg <= 1'b0;
    end else if (cfgWr) begin
      enReg     <= cfgEnable;
      stableReg <= 1'b0;
    end else if (expire) begin
      stableReg <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       maskReg <= 1'b0;
    else if (maskWr) maskReg <= maskVal;
  end

  assign oscModeSel = enReg;
  assign stable     = stableReg;
  assign irq        = stableReg && maskReg;

  // R2: an enable write drops stable and raises mode select
  a_r2_start_clears : assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgEnable) |=> (!stable && oscModeSel));

  // R3: a disable write drops stable and mode select
  a_r3_stop_clears : assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgEnable) |=> (!stable && !oscModeSel));

  // R8: stable persists until a configuration write
  a_r8_stable_holds : assert property (@(posedge clk) disable iff (!rstN)
    (stable && !cfgWr) |=> stable);

  // R4: stable can only rise while the oscillator is enabled
  a_r4_rise_enabled : assert property (@(posedge clk) disable iff (!rstN)
    $rose(stable) |-> (oscModeSel && $past(oscModeSel)));

  // R9: an interrupt request needs the stable flag
  a_r9_irq_needs_stable : assert property (@(posedge clk) disable iff (!rstN)
    irq |-> stable);
endmodule

// File: rtl/osc_startup_delay.sv
module osc_startup_delay
  import osc_startup_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             maskWr,
  input  logic             maskVal,
  input  logic             slowTick,
  output logic             oscModeSel,
  output logic             stable,
  output logic             irq
);
  dpStrobe_t dpStrobe;
  logic      expire;

  osc_start_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgEnable  (cfgEnable),
    .maskWr     (maskWr),
    .maskVal    (maskVal),
    .slowTick   (slowTick),
    .expire     (expire),
    .strobe     (dpStrobe),
    .oscModeSel (oscModeSel),
    .stable     (stable),
    .irq        (irq)
  );

  osc_start_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (dpStrobe),
    .loadValue (cfgCount),
    .expire    (expire)
  );

  // R1: nothing is reported while the oscillator is off
  a_r1_off_quiet : assert property (@(posedge clk) disable iff (!rstN)
    !oscModeSel |-> (!stable && !irq));
endmodule

// File: tb/osc_startup_delay_test.sv
module osc_startup_delay_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [7:0] cfgCount = '0;
  logic       maskWr = 1'b0;
  logic       maskVal = 1'b0;
  logic       slowTick = 1'b0;
  logic       oscModeSel, stable, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osc_startup_delay uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgCount(cfgCount), .maskWr(maskWr), .maskVal(maskVal),
    .slowTick(slowTick), .oscModeSel(oscModeSel), .stable(stable), .irq(irq)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mode,stable,irq} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic en, logic [7:0] cnt, logic tick);
    @(negedge clk);
    cfgWr = 1'b1; cfgEnable = en; cfgCount = cnt; slowTick = tick;
    @(negedge clk);
    cfgWr = 1'b0; slowTick = 1'b0;
  endtask

  task automatic writeMask(logic v);
    @(negedge clk);
    maskWr = 1'b1; maskVal = v;
    @(negedge clk);
    maskWr = 1'b0;
  endtask

  // give n ticks back to back, sampled at the falling edge after the last one
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      slowTick = 1'b1;
      @(negedge clk);
    end
    slowTick = 1'b0;
  endtask

  // sweep one count: 1 tick short, then the final tick
  task automatic sweepOne(logic [7:0] n);
    int need = (n == 0) ? 8 : 8 * int'(n);
    writeCfg(1'b1, n, 1'b0);
    check("R2", {oscModeSel, stable, irq}, 3'b100);
    ticks(need - 1);
    check(n == 0 ? "R5" : "R4", {oscModeSel, stable, irq}, 3'b100);
    ticks(1);
    check(n == 0 ? "R5" : "R4", {oscModeSel, stable, irq}, 3'b111);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {oscModeSel, stable, irq}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {oscModeSel, stable, irq}, 3'b000);

    // R6: ticks while disabled do nothing
    ticks(40);
    check("R6", {oscModeSel, stable, irq}, 3'b000);

    // R1: mask resets to 0, so irq stays low at stable
    writeCfg(1'b1, 8'd1, 1'b0);
    ticks(8);
    check("R1", {oscModeSel, stable, irq}, 3'b110);

    // R9: irq follows mask
    writeMask(1'b1);
    check("R9", {oscModeSel, stable, irq}, 3'b111);
    writeMask(1'b0);
    check("R9", {oscModeSel, stable, irq}, 3'b110);
    writeMask(1'b1);

    // R8: stable holds through further ticks
    ticks(100);
    check("R8", {oscModeSel, stable, irq}, 3'b111);

    // R3: disable clears
    writeCfg(1'b0, 8'd5, 1'b0);
    check("R3", {oscModeSel, stable, irq}, 3'b000);

    // R4/R5 sweeps over small and large counts
    for (int n = 0; n <= 20; n++) sweepOne(8'(n));
    for (int n = 250; n <= 255; n++) sweepOne(8'(n));

    // R2: re-enable while stable clears and restarts
    writeCfg(1'b1, 8'd2, 1'b0);
    check("R2", {oscModeSel, stable, irq}, 3'b100);
    ticks(15);
    check("R2", {oscModeSel, stable, irq}, 3'b100);
    ticks(1);
    check("R2", {oscModeSel, stable, irq}, 3'b111);

    // R7: partial prescaler before re-enable does not count
    writeCfg(1'b1, 8'd2, 1'b0);
    ticks(5);
    writeCfg(1'b1, 8'd1, 1'b0);
    ticks(7);
    check("R7", {oscModeSel, stable, irq}, 3'b100);
    ticks(1);
    check("R7", {oscModeSel, stable, irq}, 3'b111);

    // R6: tick coincident with write is ignored
    writeCfg(1'b1, 8'd1, 1'b1);
    ticks(7);
    check("R6", {oscModeSel, stable, irq}, 3'b100);
    ticks(1);
    check("R6", {oscModeSel, stable, irq}, 3'b111);

    // R3: disable in the middle of a countdown
    writeCfg(1'b1, 8'd3, 1'b0);
    ticks(10);
    writeCfg(1'b0, 8'd0, 1'b0);
    ticks(30);
    check("R3", {oscModeSel, stable, irq}, 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule